// File: doc/BRIEF.md
# Programmable Video Blanking Generator

This block produces the blanking flag that separates the visible part of a raster from its horizontal and vertical retrace intervals. It runs a pixel counter that restarts on every horizontal sync reference and a line counter that restarts at the start of each field. Both counts are compared with four programmable limits: where horizontal blanking begins, where it ends, the first blanked line at the bottom of the field and the first visible line at the top. The result is a registered blank output that travels with the two counts.

A downstream capture stage uses the blank output to decide which samples belong to the visible picture. The limits arrive as plain input ports and are meant to be held steady while the raster runs. Horizontal edges are placed with two-pixel resolution, because the compare ignores the lowest bit of the pixel count. Vertical blanking always covers whole lines. The count and flag outputs pass through a fixed pipeline of `OUT_LAT` registers, so that they line up with video data that is delayed by the same amount.

Top module: `vid_blank_gen`

## Requirements
- R1: After reset, blank_o is 1 and px_cnt_o and ln_cnt_o are 0. They stay so until the first clock on which pix_en and hs_ref are both high.
- R2: On a clock with pix_en high and hs_ref high, the pixel count becomes 0. On other clocks with pix_en high it rises by 1. When pix_en is low, both counts and the blank state hold.
- R3: The pixel count saturates at its all-ones value (1023 with default widths) when no sync reference arrives.
- R4: On each enabled sync reference, the line count becomes 0 if fs_ref is also high, and otherwise rises by 1, saturating at all-ones.
- R5: On a visible line, blank goes low on the count whose value with bit 0 cleared equals hb_end_i with bit 0 cleared.
- R6: On a visible line, blank goes high on the count whose value with bit 0 cleared equals hb_start_i with bit 0 cleared. When both limits fall in the same two-pixel pair, the end limit wins and blank goes low.
- R7: A line whose number is at least vb_start_i, or less than vb_end_i, is blanked for every count of that line.
- R8: Every line starts blanked at count 0, unless hb_end_i is 0 or 1, in which case the line is visible from count 0.
- R9: blank_o, px_cnt_o and ln_cnt_o show the internal flag and counts delayed by OUT_LAT clocks (2 by default), all three aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable; counters advance only when high |
| hs_ref | input | 1 | Horizontal sync reference; restarts the pixel count |
| fs_ref | input | 1 | Field start; taken together with hs_ref to zero the line count |
| hb_start_i | input | HS_W (10) | Pixel count at which horizontal blanking begins |
| hb_end_i | input | HE_W (8) | Pixel count at which horizontal blanking ends |
| vb_start_i | input | VS_W (9) | First line of the bottom vertical blanking interval |
| vb_end_i | input | VE_W (8) | First visible line after the top of the field |
| blank_o | output | 1 | Blanking flag, 1 outside the visible region |
| px_cnt_o | output | PIX_W (10) | Pixel count aligned with blank_o |
| ln_cnt_o | output | LINE_W (9) | Line count aligned with blank_o |

## Verification
The hardest cases to reach from the ports are the ordering cases of the horizontal limits: odd values that share a pair with their even neighbour, a start and an end in the same pair, a start placed before the end, and an end in pair 0 that opens the line at its first count. The bench drives short synthetic lines of 40 pixels, with and without gaps in the pixel enable, under a set of limit combinations chosen to hit each of these cases. For every combination it predicts the flag from the last limit pair passed at or below the current count. One full-width line sequence with the standard 525-line values, and a long run without sync that drives the pixel counter into saturation, complete the stimulus.

// File: rtl/vbg_pkg.sv
package vbg_pkg;

    // Common compare width; callers zero-extend their narrower fields.
    localparam int CMP_W = 16;
    typedef logic [CMP_W-1:0] cmp_t;

    // What a horizontal compare asks of the visible-region state.
    typedef enum logic [1:0] {
        HB_KEEP  = 2'd0,
        HB_OPEN  = 2'd1,
        HB_CLOSE = 2'd2
    } hb_evt_e;

    // Two counts fall in the same two-pixel pair.
    function automatic logic same_pair(cmp_t a, cmp_t b);
        return a[CMP_W-1:1] == b[CMP_W-1:1];
    endfunction

    // The opening limit takes priority when both limits share a pair.
    function automatic hb_evt_e classify(cmp_t cnt, cmp_t open_at, cmp_t close_at);
        if (same_pair(cnt, open_at))
            return HB_OPEN;
        else if (same_pair(cnt, close_at))
            return HB_CLOSE;
        else
            return HB_KEEP;
    endfunction

    // A line is blanked when it lies at or past the bottom limit or
    // before the top limit.
    function automatic logic line_dead(cmp_t ln, cmp_t bottom, cmp_t top);
        return (ln >= bottom) || (ln < top);
    endfunction

endpackage

// File: rtl/vbg_pix_ctr.sv
module vbg_pix_ctr #(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             hs_ref,
    output logic             seen_q,
    output logic             seen_d,
    output logic [PIX_W-1:0] px_q,
    output logic [PIX_W-1:0] px_d
);

    localparam logic [PIX_W-1:0] PX_MAX = {PIX_W{1'b1}};

    always_comb begin
        seen_d = seen_q;
        px_d   = px_q;
        if (pix_en) begin
            if (hs_ref) begin
                seen_d = 1'b1;
                px_d   = '0;
            end else if (seen_q && (px_q != PX_MAX)) begin
                px_d = px_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            px_q   <= '0;
        end else begin
            seen_q <= seen_d;
            px_q   <= px_d;
        end
    end

endmodule

// File: rtl/vbg_line_ctr.sv
module vbg_line_ctr #(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_tick,
    input  logic              fs_ref,
    output logic [LINE_W-1:0] ln_q,
    output logic [LINE_W-1:0] ln_d
);

    localparam logic [LINE_W-1:0] LN_MAX = {LINE_W{1'b1}};

    always_comb begin
        ln_d = ln_q;
        if (line_tick) begin
            if (fs_ref)
                ln_d = '0;
            else if (ln_q != LN_MAX)
                ln_d = ln_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ln_q <= '0;
        else
            ln_q <= ln_d;
    end

endmodule

// File: rtl/vbg_blank_ctl.sv
module vbg_blank_ctl
    import vbg_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int LINE_W = 9,
    parameter int HS_W   = 10,
    parameter int HE_W   = 8,
    parameter int VS_W   = 9,
    parameter int VE_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    input  logic              line_tick,
    input  logic              seen_d,
    input  logic [PIX_W-1:0]  px_d,
    input  logic [LINE_W-1:0] ln_d,
    input  logic [HS_W-1:0]   hb_start,
    input  logic [HE_W-1:0]   hb_end,
    input  logic [VS_W-1:0]   vb_start,
    input  logic [VE_W-1:0]   vb_end,
    output logic              blank_q
);

    logic    open_q;
    logic    open_d;
    logic    dead_line;
    logic    step;
    hb_evt_e evt;

    assign step      = pix_en && seen_d;
    assign evt       = classify(cmp_t'(px_d), cmp_t'(hb_end), cmp_t'(hb_start));
    assign dead_line = line_dead(cmp_t'(ln_d), cmp_t'(vb_start), cmp_t'(vb_end));

    always_comb begin
        open_d = open_q;
        if (step) begin
            if (line_tick)
                open_d = 1'b0;
            case (evt)
                HB_OPEN:  open_d = 1'b1;
                HB_CLOSE: open_d = 1'b0;
                default:  ;
            endcase
        end
        // Vertical blanking and the pre-sync state override every cycle.
        if (dead_line || !seen_d)
            open_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            blank_q <= 1'b1;
        end else begin
            open_q  <= open_d;
            blank_q <= ~open_d;
        end
    end

endmodule

// File: rtl/vbg_out_pipe.sv
module vbg_out_pipe #(
    parameter int           W       = 20,
    parameter int           LAT     = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (LAT == 0) begin : g_bypass
            assign q = d;
        end else begin : g_stages
            logic [W-1:0] stg [LAT];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < LAT; i++)
                        stg[i] <= RST_VAL;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < LAT; i++)
                        stg[i] <= stg[i-1];
                end
            end
            assign q = stg[LAT-1];
        end
    endgenerate

endmodule

// File: rtl/vid_blank_gen.sv
module vid_blank_gen #(
    parameter int PIX_W   = 10,
    parameter int LINE_W  = 9,
    parameter int HS_W    = 10,
    parameter int HE_W    = 8,
    parameter int VS_W    = 9,
    parameter int VE_W    = 8,
    parameter int OUT_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_en,
    input  logic              hs_ref,
    input  logic              fs_ref,
    input  logic [HS_W-1:0]   hb_start_i,
    input  logic [HE_W-1:0]   hb_end_i,
    input  logic [VS_W-1:0]   vb_start_i,
    input  logic [VE_W-1:0]   vb_end_i,
    output logic              blank_o,
    output logic [PIX_W-1:0]  px_cnt_o,
    output logic [LINE_W-1:0] ln_cnt_o
);

    localparam int TUP_W = 1 + PIX_W + LINE_W;
    localparam logic [TUP_W-1:0] TUP_RST = {1'b1, {(PIX_W+LINE_W){1'b0}}};

    typedef struct packed {
        logic              blank;
        logic [PIX_W-1:0]  px;
        logic [LINE_W-1:0] ln;
    } tuple_t;

    logic              seen_q;
    logic              seen_d;
    logic [PIX_W-1:0]  px_q;
    logic [PIX_W-1:0]  px_d;
    logic [LINE_W-1:0] ln_q;
    logic [LINE_W-1:0] ln_d;
    logic              blank_core;
    logic              line_tick;
    tuple_t            core_tup;
    tuple_t            out_tup;

    assign line_tick = pix_en && hs_ref;

    vbg_pix_ctr #(.PIX_W(PIX_W)) u_pix (
        .clk    (clk),
        .rst    (rst),
        .pix_en (pix_en),
        .hs_ref (hs_ref),
        .seen_q (seen_q),
        .seen_d (seen_d),
        .px_q   (px_q),
        .px_d   (px_d)
    );

    vbg_line_ctr #(.LINE_W(LINE_W)) u_line (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .fs_ref    (fs_ref),
        .ln_q      (ln_q),
        .ln_d      (ln_d)
    );

    vbg_blank_ctl #(
        .PIX_W (PIX_W),
        .LINE_W(LINE_W),
        .HS_W  (HS_W),
        .HE_W  (HE_W),
        .VS_W  (VS_W),
        .VE_W  (VE_W)
    ) u_blank (
        .clk       (clk),
        .rst       (rst),
        .pix_en    (pix_en),
        .line_tick (line_tick),
        .seen_d    (seen_d),
        .px_d      (px_d),
        .ln_d      (ln_d),
        .hb_start  (hb_start_i),
        .hb_end    (hb_end_i),
        .vb_start  (vb_start_i),
        .vb_end    (vb_end_i),
        .blank_q   (blank_core)
    );

    assign core_tup = '{blank: blank_core, px: px_q, ln: ln_q};

    vbg_out_pipe #(
        .W      (TUP_W),
        .LAT    (OUT_LAT),
        .RST_VAL(TUP_RST)
    ) u_pipe (
        .clk (clk),
        .rst (rst),
        .d   (core_tup),
        .q   (out_tup)
    );

    assign blank_o  = out_tup.blank;
    assign px_cnt_o = out_tup.px;
    assign ln_cnt_o = out_tup.ln;

endmodule

// File: rtl/vbg_checker.sv
module vbg_checker #(
    parameter int PIX_W   = 10,
    parameter int LINE_W  = 9,
    parameter int VS_W    = 9,
    parameter int VE_W    = 8,
    parameter int OUT_LAT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              pix_en,
    input logic              hs_ref,
    input logic              fs_ref,
    input logic [VS_W-1:0]   vb_start_i,
    input logic [VE_W-1:0]   vb_end_i,
    input logic              seen_q,
    input logic [PIX_W-1:0]  px_q,
    input logic [LINE_W-1:0] ln_q,
    input logic              blank_core,
    input logic              blank_o,
    input logic [PIX_W-1:0]  px_cnt_o,
    input logic [LINE_W-1:0] ln_cnt_o
);

    localparam int TUP_W = 1 + PIX_W + LINE_W;

    logic [TUP_W-1:0] core_v;
    logic [TUP_W-1:0] out_v;
    logic [TUP_W-1:0] ref_v;

    assign core_v = {blank_core, px_q, ln_q};
    assign out_v  = {blank_o, px_cnt_o, ln_cnt_o};

    assert_presync_R1: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> (blank_core && px_q == '0 && ln_q == '0));

    assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (pix_en && hs_ref) |=> (px_q == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(px_q) && $stable(ln_q) && $stable(blank_core)));

    assert_saturate_R3: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !hs_ref && (&px_q)) |=> (&px_q));

    assert_field_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (pix_en && hs_ref && fs_ref) |=> (ln_q == '0));

    assert_vdead_R7: assert property (@(posedge clk) disable iff (rst)
        (!pix_en && (int'(ln_q) >= int'(vb_start_i) || int'(ln_q) < int'(vb_end_i)))
        |=> blank_core);

    // Reference delay line for the output alignment check.
    generate
        if (OUT_LAT == 0) begin : g_ref0
            assign ref_v = core_v;
        end else begin : g_refn
            logic [TUP_W-1:0] dly [OUT_LAT];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < OUT_LAT; i++)
                        dly[i] <= {1'b1, {(PIX_W+LINE_W){1'b0}}};
                end else begin
                    dly[0] <= core_v;
                    for (int i = 1; i < OUT_LAT; i++)
                        dly[i] <= dly[i-1];
                end
            end
            assign ref_v = dly[OUT_LAT-1];
        end
    endgenerate

    assert_align_R9: assert property (@(posedge clk) disable iff (rst)
        out_v == ref_v);

endmodule

bind vid_blank_gen vbg_checker #(
    .PIX_W  (PIX_W),
    .LINE_W (LINE_W),
    .VS_W   (VS_W),
    .VE_W   (VE_W),
    .OUT_LAT(OUT_LAT)
) u_vbg_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_en     (pix_en),
    .hs_ref     (hs_ref),
    .fs_ref     (fs_ref),
    .vb_start_i (vb_start_i),
    .vb_end_i   (vb_end_i),
    .seen_q     (seen_q),
    .px_q       (px_q),
    .ln_q       (ln_q),
    .blank_core (blank_core),
    .blank_o    (blank_o),
    .px_cnt_o   (px_cnt_o),
    .ln_cnt_o   (ln_cnt_o)
);

// File: tb/tb_vid_blank_gen.sv
module tb_vid_blank_gen;

    localparam int CLK_NS  = 10;
    localparam int OUT_LAT = 2;
    localparam int PX_MAX  = 1023;
    localparam int LN_MAX  = 511;
    localparam int HDEPTH  = 4096;
    localparam int WD_MAX  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_en = 1'b0;
    logic       hs_ref = 1'b0;
    logic       fs_ref = 1'b0;
    logic [9:0] hb_start_i = '0;
    logic [7:0] hb_end_i = '0;
    logic [8:0] vb_start_i = '0;
    logic [7:0] vb_end_i = '0;
    logic       blank_o;
    logic [9:0] px_cnt_o;
    logic [8:0] ln_cnt_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // Bench model state and history of expected outputs.
    int m_h, m_l;
    bit m_seen;
    int n;
    int hist_h [HDEPTH];
    int hist_l [HDEPTH];
    bit hist_b [HDEPTH];
    bit hist_s [HDEPTH];

    vid_blank_gen #(.OUT_LAT(OUT_LAT)) dut (
        .clk        (clk),
        .rst        (rst),
        .pix_en     (pix_en),
        .hs_ref     (hs_ref),
        .fs_ref     (fs_ref),
        .hb_start_i (hb_start_i),
        .hb_end_i   (hb_end_i),
        .vb_start_i (vb_start_i),
        .vb_end_i   (vb_end_i),
        .blank_o    (blank_o),
        .px_cnt_o   (px_cnt_o),
        .ln_cnt_o   (ln_cnt_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Visible-region decision: the last limit pair at or below the count
    // decides; the end pair wins a tie (R5, R6, R8).
    function automatic bit h_open(int h);
        int c = h / 2;
        int e = int'(hb_end_i) / 2;
        int s = int'(hb_start_i) / 2;
        bit pe = (c >= e);
        bit ps = (c >= s);
        if (!pe) return 1'b0;
        if (!ps) return 1'b1;
        return (e >= s);
    endfunction

    function automatic bit l_dead(int l);
        return (l >= int'(vb_start_i)) || (l < int'(vb_end_i));
    endfunction

    function automatic bit exp_blank(bit seen, int h, int l);
        return !seen || l_dead(l) || !h_open(h);
    endfunction

    task automatic report(string tag, string what, int act, int exp);
        fails++;
        $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, n);
    endtask

    task automatic compare_out();
        int  k = n - OUT_LAT;   // R9: outputs trail the core by OUT_LAT clocks
        int  eh, el;
        bit  eb, es;
        string tag;
        if (k < 0) begin
            eh = 0; el = 0; eb = 1'b1; es = 1'b0;
        end else begin
            eh = hist_h[k % HDEPTH]; el = hist_l[k % HDEPTH];
            eb = hist_b[k % HDEPTH]; es = hist_s[k % HDEPTH];
        end
        checks++;
        if (int'(px_cnt_o) != eh || int'(ln_cnt_o) != el || blank_o != eb) begin
            if (int'(px_cnt_o) != eh) report("R2", "pixel count", int'(px_cnt_o), eh);
            else if (int'(ln_cnt_o) != el) report("R4", "line count", int'(ln_cnt_o), el);
            else begin
                if (!es) tag = "R1";
                else if (l_dead(el)) tag = "R7";
                else if (eh < 2) tag = "R8";
                else if (!eb) tag = "R5";
                else tag = "R6";
                report(tag, "blank", int'(blank_o), int'(eb));
            end
        end
    endtask

    task automatic step(bit pe, bit hs, bit fs);
        pix_en = pe; hs_ref = hs; fs_ref = fs;
        if (pe) begin
            if (hs) begin
                m_seen = 1'b1;
                m_h = 0;
                m_l = fs ? 0 : ((m_l == LN_MAX) ? LN_MAX : m_l + 1);
            end else if (m_seen && m_h != PX_MAX) begin
                m_h = m_h + 1;
            end
        end
        hist_h[n % HDEPTH] = m_h;
        hist_l[n % HDEPTH] = m_l;
        hist_s[n % HDEPTH] = m_seen;
        hist_b[n % HDEPTH] = exp_blank(m_seen, m_h, m_l);
        @(posedge clk); #1;
        compare_out();
        n++;
    endtask

    task automatic do_reset();
        rst = 1'b1; pix_en = 1'b0; hs_ref = 1'b0; fs_ref = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        m_h = 0; m_l = 0; m_seen = 1'b0; n = 0;
    endtask

    task automatic run_line(int len, bit fs, int gap);
        for (int i = 0; i < len; i++) begin
            step(1'b1, i == 0, fs && (i == 0));
            if (gap > 0 && (i % gap) == gap - 1)
                step(1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic run_cfg(int hs, int he, int vs, int ve, int gap);
        hb_start_i = 10'(hs); hb_end_i = 8'(he);
        vb_start_i = 9'(vs);  vb_end_i = 8'(ve);
        do_reset();
        // R1: enabled pixels without a sync reference leave the reset state.
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0);
        checks++;
        if (blank_o !== 1'b1 || px_cnt_o !== 10'd0)
            report("R1", "pre-sync blank", int'(blank_o), 1);
        for (int f = 0; f < 2; f++)
            for (int l = 0; l < 12; l++)
                run_line(40, l == 0, gap);
        for (int i = 0; i < OUT_LAT + 1; i++) step(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_MAX) begin
                fails++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        // Short raster sweeps over limit orderings.
        run_cfg(30, 6, 8, 2, 0);    // even limits
        run_cfg(31, 7, 8, 2, 3);    // odd limits share their pairs, enable gaps
        run_cfg(29, 5, 7, 1, 0);
        run_cfg(12, 12, 9, 3, 0);   // same pair: end wins
        run_cfg(13, 12, 9, 3, 4);
        run_cfg(10, 20, 8, 2, 0);   // start before end
        run_cfg(38, 0, 10, 0, 0);   // visible from count 0, no top blanking
        run_cfg(36, 1, 11, 0, 2);
        run_cfg(50, 4, 9, 1, 0);    // start beyond line length
        run_cfg(20, 8, 0, 0, 0);    // every line blanked

        // R3: no sync for longer than the counter range.
        do_reset();
        step(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 1100; i++) step(1'b1, 1'b0, 1'b0);
        checks++;
        if (int'(px_cnt_o) != PX_MAX)
            report("R3", "saturated count", int'(px_cnt_o), PX_MAX);

        // Standard 525-line rectangular-pixel limits over 21 full lines.
        hb_start_i = 10'd842; hb_end_i = 8'd122;
        vb_start_i = 9'd259;  vb_end_i = 8'd19;
        do_reset();
        for (int l = 0; l < 21; l++) run_line(858, l == 0, 0);
        for (int i = 0; i < OUT_LAT + 1; i++) step(1'b0, 1'b0, 1'b0);
        checks++;
        if (int'(ln_cnt_o) != 20)
            report("R4", "line count after 21 lines", int'(ln_cnt_o), 20);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule